// File: doc/BRIEF.md
# Bus Transceiver Mode and Wake-up Controller

This block is the digital control core of a single-wire vehicle bus transceiver. It tracks four operating modes (unpowered, pre-normal, normal and sleep) from a supply comparator, a debounced enable pin and two wake-up inputs. From the mode it drives the regulator inhibit switch, the transmit/receive path and the bus termination. Analog thresholds and pin drivers sit outside the block.

Two wake-up paths are watched while the device sleeps: the bus line and a local wake pin. Each path is edge-qualified, so a line that is already low when sleep starts cannot wake the device. Each path also has a duration filter that counts microsecond ticks. A qualified wake-up moves the device to pre-normal mode and raises a request flag, which appears as an open-drain low on the receive-data pin. It also sets a source flag, which appears as a strong pull-down on the transmit-data pin for a local wake-up. Otherwise the normal weak pull-down stays on that pin. Both flags clear as soon as the raw enable pin is high.

Top module: `lin_mode_ctrl`

## Requirements
- R1: During and after reset the block is unpowered. All of inhibit_en, path_en, term_en, rxd_pull_low and txd_strong_pd are 0, and txd_weak_pd is 1.
- R2: In the unpowered mode, supply_hi = 1 leads to pre-normal mode: inhibit_en = 1, term_en = 1, path_en = 0.
- R3: In pre-normal mode, an enable_pin held at 1 for EN_ON_US microseconds leads to normal mode: inhibit_en, path_en and term_en are all 1.
- R4: In normal mode, an enable_pin held at 0 for EN_OFF_US microseconds leads to sleep mode: inhibit_en, path_en and term_en are all 0.
- R5: An enable_pin pulse shorter than (EN_ON_US-1) microseconds does not change the mode.
- R6: A bus wake-up needs a falling edge of bus_level (1 = recessive, 0 = dominant) seen during sleep. A dominant level shorter than (BUS_FILT_US-1) microseconds does not wake the device, and neither does a dominant level that was already present when sleep began.
- R7: Dominant bus_level held for BUS_FILT_US microseconds after a falling edge in sleep leads to pre-normal mode with rxd_pull_low = 1, txd_strong_pd = 0 and txd_weak_pd = 1.
- R8: wake_level (1 = idle) falling and then held low for WAKE_FILT_US microseconds in sleep leads to pre-normal mode with rxd_pull_low = 1, txd_strong_pd = 1 and txd_weak_pd = 0. Exactly one of the two transmit pull-downs is on at all times.
- R9: While enable_pin is 1, rxd_pull_low and txd_strong_pd are 0 within two clock cycles, before the enable debounce completes.
- R10: In sleep mode, a debounced enable_pin = 1 leads directly to normal mode.
- R11: supply_lo = 1 forces the unpowered mode from any mode. The outputs show it two cycles later.
- R12: If both wake-up filters qualify in the same cycle, the local source wins: txd_strong_pd = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_hi | input | 1 | Supply above the power-up threshold |
| supply_lo | input | 1 | Supply below the power-down threshold |
| enable_pin | input | 1 | Mode enable from the host controller |
| bus_level | input | 1 | Sampled bus level, 0 = dominant |
| wake_level | input | 1 | Local wake pin level, 0 = active |
| inhibit_en | output | 1 | Regulator inhibit high-side switch on |
| path_en | output | 1 | Transmit and receive path enabled |
| term_en | output | 1 | Bus termination on (weak pull-up when 0) |
| rxd_pull_low | output | 1 | Open-drain low on receive data (wake request) |
| txd_strong_pd | output | 1 | Strong pull-down on transmit data (local source) |
| txd_weak_pd | output | 1 | Weak pull-down on transmit data |

## Verification
Supply changes show on the outputs two cycles after they are sampled: one register for the mode and one for the pin stage. The enable-flag clear also takes two cycles. The bench therefore compares three cycles after it drives one of these inputs. The timed paths (enable debounce and both wake filters) end within one tick period of their nominal length. Their stimuli are held either at least one tick plus a margin beyond the threshold, or at least two ticks below it, and the compare follows a settling wait. Each expected pattern is queued only after the stimulus has settled, and it is compared while the inputs stay constant.

// File: rtl/lin_mode_pkg.sv
// Package: shared mode encoding for the transceiver mode controller.
// Assumes: nothing beyond 2-bit storage for the mode register.
package lin_mode_pkg;

    typedef enum logic [1:0] {
        MD_OFF   = 2'd0,
        MD_PRE   = 2'd1,
        MD_NORM  = 2'd2,
        MD_SLEEP = 2'd3
    } mode_t;

endpackage

// File: rtl/lin_us_tick.sv
// Module: free-running divider that emits a one-cycle pulse once per
// microsecond. Assumes DIV is the number of clock cycles per microsecond
// and is at least 2.
module lin_us_tick #(
    parameter int DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DW = $clog2(DIV + 1);
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] div_q;

    // Count clock cycles and pulse on the last one of each period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            tick  <= 1'b0;
        end else if (div_q == LAST) begin
            div_q <= '0;
            tick  <= 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
            tick  <= 1'b0;
        end
    end
endmodule

// File: rtl/lin_wake_filter.sv
// Module: edge-qualified duration filter for one wake-up source.
// The filter arms on a high-to-low transition of lvl seen while arm_en is
// set. It then counts microsecond ticks while lvl stays low and emits a
// one-cycle fire pulse after THR_US ticks. A return high disarms it.
// Assumes lvl is already synchronous to clk.
module lin_wake_filter #(
    parameter int THR_US = 90,
    parameter int CW     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic arm_en,
    input  logic lvl,
    output logic fire
);
    localparam logic [CW-1:0] LAST = CW'(THR_US - 1);

    logic          prev_q;
    logic          armed_q;
    logic [CW-1:0] cnt_q;

    // Keep the previous sample so that edges are seen even on the first armed cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= lvl;
    end

    // Arm on a falling edge, count low time, fire once at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm_en) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
            fire    <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (!armed_q) begin
                if (prev_q && !lvl) begin
                    armed_q <= 1'b1;
                    cnt_q   <= '0;
                end
            end else if (lvl) begin
                armed_q <= 1'b0;
                cnt_q   <= '0;
            end else if (tick) begin
                if (cnt_q == LAST) begin
                    fire    <= 1'b1;
                    armed_q <= 1'b0;
                    cnt_q   <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lin_en_debounce.sv
// Module: asymmetric debouncer for the enable pin. The debounced value
// follows the raw pin only after the pin has differed from it for ON_US
// ticks (rising) or OFF_US ticks (falling) without interruption.
// Assumes raw is already synchronous to clk.
module lin_en_debounce #(
    parameter int ON_US  = 10,
    parameter int OFF_US = 12,
    parameter int CW     = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw,
    output logic deb
);
    localparam logic [CW-1:0] ON_LAST  = CW'(ON_US - 1);
    localparam logic [CW-1:0] OFF_LAST = CW'(OFF_US - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    // Pick the hold time for the direction of the pending change.
    always_comb lim = raw ? ON_LAST : OFF_LAST;

    // Count ticks of disagreement and commit the new level at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deb   <= 1'b0;
            cnt_q <= '0;
        end else if (raw == deb) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (cnt_q == lim) begin
                deb   <= raw;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lin_mode_fsm.sv
// Module: operating-mode state machine with the wake request and wake
// source flags. The supply-low input overrides everything else. The raw
// enable pin clears both flags at once; mode changes use the debounced
// enable. Assumes the fire inputs are single-cycle pulses.
module lin_mode_fsm
    import lin_mode_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  supply_hi,
    input  logic  supply_lo,
    input  logic  en_raw,
    input  logic  en_deb,
    input  logic  bus_fire,
    input  logic  wake_fire,
    output mode_t mode,
    output logic  req_flag,
    output logic  local_flag
);
    mode_t mode_d;
    logic  req_d;
    logic  local_d;

    // Next mode and flags from the current mode and the qualified events.
    always_comb begin
        mode_d  = mode;
        req_d   = req_flag;
        local_d = local_flag;
        if (supply_lo) begin
            mode_d  = MD_OFF;
            req_d   = 1'b0;
            local_d = 1'b0;
        end else begin
            unique case (mode)
                MD_OFF: begin
                    req_d   = 1'b0;
                    local_d = 1'b0;
                    if (supply_hi) mode_d = MD_PRE;
                end
                MD_PRE: begin
                    if (en_deb) mode_d = MD_NORM;
                end
                MD_NORM: begin
                    if (!en_deb) mode_d = MD_SLEEP;
                end
                MD_SLEEP: begin
                    if (en_deb) begin
                        mode_d = MD_NORM;
                    end else if (wake_fire) begin
                        mode_d  = MD_PRE;
                        req_d   = 1'b1;
                        local_d = 1'b1;
                    end else if (bus_fire) begin
                        mode_d  = MD_PRE;
                        req_d   = 1'b1;
                        local_d = 1'b0;
                    end
                end
                default: mode_d = MD_OFF;
            endcase
            if (en_raw) begin
                req_d   = 1'b0;
                local_d = 1'b0;
            end
        end
    end

    // Hold the mode and the two flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode       <= MD_OFF;
            req_flag   <= 1'b0;
            local_flag <= 1'b0;
        end else begin
            mode       <= mode_d;
            req_flag   <= req_d;
            local_flag <= local_d;
        end
    end
endmodule

// File: rtl/lin_mode_ctrl.sv
// Module: top of the transceiver mode and wake-up controller. It ties
// together the tick divider, the enable debouncer, the two wake filters
// and the mode machine, and registers the pin-driver enables.
// Assumes all inputs are synchronous to clk (comparators and pins are
// synchronised outside this block).
module lin_mode_ctrl
    import lin_mode_pkg::*;
#(
    parameter int TICK_DIV     = 100,
    parameter int BUS_FILT_US  = 90,
    parameter int WAKE_FILT_US = 130,
    parameter int EN_ON_US     = 10,
    parameter int EN_OFF_US    = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_hi,
    input  logic supply_lo,
    input  logic enable_pin,
    input  logic bus_level,
    input  logic wake_level,
    output logic inhibit_en,
    output logic path_en,
    output logic term_en,
    output logic rxd_pull_low,
    output logic txd_strong_pd,
    output logic txd_weak_pd
);
    localparam int FILT_MAX = (BUS_FILT_US > WAKE_FILT_US) ? BUS_FILT_US : WAKE_FILT_US;
    localparam int EN_MAX   = (EN_ON_US > EN_OFF_US) ? EN_ON_US : EN_OFF_US;
    localparam int FCW      = $clog2(FILT_MAX + 1);
    localparam int ECW      = $clog2(EN_MAX + 1);

    logic  us_tick;
    logic  en_deb;
    logic  bus_fire;
    logic  wake_fire;
    logic  in_sleep;
    mode_t mode;
    logic  req_flag;
    logic  local_flag;

    lin_us_tick #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (us_tick)
    );

    lin_en_debounce #(.ON_US(EN_ON_US), .OFF_US(EN_OFF_US), .CW(ECW)) u_endb (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (us_tick),
        .raw  (enable_pin),
        .deb  (en_deb)
    );

    // Wake filters listen only while the device sleeps.
    always_comb in_sleep = (mode == MD_SLEEP);

    lin_wake_filter #(.THR_US(BUS_FILT_US), .CW(FCW)) u_busf (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (us_tick),
        .arm_en(in_sleep),
        .lvl   (bus_level),
        .fire  (bus_fire)
    );

    lin_wake_filter #(.THR_US(WAKE_FILT_US), .CW(FCW)) u_wakef (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (us_tick),
        .arm_en(in_sleep),
        .lvl   (wake_level),
        .fire  (wake_fire)
    );

    lin_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_hi (supply_hi),
        .supply_lo (supply_lo),
        .en_raw    (enable_pin),
        .en_deb    (en_deb),
        .bus_fire  (bus_fire),
        .wake_fire (wake_fire),
        .mode      (mode),
        .req_flag  (req_flag),
        .local_flag(local_flag)
    );

    // Register the pin-driver enables decoded from the mode and the flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inhibit_en    <= 1'b0;
            path_en       <= 1'b0;
            term_en       <= 1'b0;
            rxd_pull_low  <= 1'b0;
            txd_strong_pd <= 1'b0;
            txd_weak_pd   <= 1'b1;
        end else begin
            inhibit_en    <= (mode == MD_PRE) || (mode == MD_NORM);
            path_en       <= (mode == MD_NORM);
            term_en       <= (mode == MD_PRE) || (mode == MD_NORM);
            rxd_pull_low  <= req_flag;
            txd_strong_pd <= req_flag && local_flag;
            txd_weak_pd   <= !(req_flag && local_flag);
        end
    end
endmodule

// File: rtl/lin_mode_ctrl_chk.sv
// Module: property checker for the mode controller, attached by bind.
// Assumes it sees only the ports of the top module.
module lin_mode_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic supply_lo,
    input logic enable_pin,
    input logic inhibit_en,
    input logic path_en,
    input logic term_en,
    input logic rxd_pull_low,
    input logic txd_strong_pd,
    input logic txd_weak_pd
);
    // R3: the communication path is only on together with inhibit and termination.
    assert_path_needs_supply_R3: assert property (@(posedge clk) disable iff (!rst_n)
        path_en |-> (inhibit_en && term_en));

    // R8: exactly one transmit pull-down is enabled.
    assert_txd_pd_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({txd_strong_pd, txd_weak_pd}));

    // R8: the strong pull-down only accompanies a wake request.
    assert_strong_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        txd_strong_pd |-> rxd_pull_low);

    // R7: a wake request is only shown in pre-normal mode (inhibit on, path off).
    assert_req_in_prenormal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rxd_pull_low |-> (inhibit_en && !path_en));

    // R9: a raw enable held for two samples clears the request flag.
    assert_enable_clears_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_pin && $past(enable_pin)) |=> !rxd_pull_low);

    // R11: supply low turns the regulator switch off two cycles later.
    assert_undervolt_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        supply_lo |=> ##1 !inhibit_en);
endmodule

bind lin_mode_ctrl lin_mode_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_lo    (supply_lo),
    .enable_pin   (enable_pin),
    .inhibit_en   (inhibit_en),
    .path_en      (path_en),
    .term_en      (term_en),
    .rxd_pull_low (rxd_pull_low),
    .txd_strong_pd(txd_strong_pd),
    .txd_weak_pd  (txd_weak_pd)
);

// File: tb/sim_lin_mode_ctrl.sv
// Bench: scoreboard for the mode controller. The driver applies stimulus,
// lets it settle and queues the expected pin pattern
// {inhibit, path, term, rxd_low, txd_strong, txd_weak}; the monitor pops
// each item at a falling edge and compares it with the outputs.
module sim_lin_mode_ctrl;
    localparam int DIV   = 10;
    localparam int BUSF  = 10;
    localparam int WAKEF = 10;
    localparam int ENON  = 3;
    localparam int ENOFF = 4;

    localparam logic [5:0] P_OFF   = 6'b000001;
    localparam logic [5:0] P_PRE   = 6'b101001;
    localparam logic [5:0] P_PRE_B = 6'b101101;
    localparam logic [5:0] P_PRE_L = 6'b101110;
    localparam logic [5:0] P_NORM  = 6'b111001;
    localparam logic [5:0] P_SLEEP = 6'b000001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_hi = 1'b0, supply_lo = 1'b0, enable_pin = 1'b0;
    logic bus_level = 1'b1, wake_level = 1'b1;
    logic inhibit_en, path_en, term_en, rxd_pull_low, txd_strong_pd, txd_weak_pd;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [5:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    lin_mode_ctrl #(
        .TICK_DIV(DIV), .BUS_FILT_US(BUSF), .WAKE_FILT_US(WAKEF),
        .EN_ON_US(ENON), .EN_OFF_US(ENOFF)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .supply_hi(supply_hi), .supply_lo(supply_lo),
        .enable_pin(enable_pin), .bus_level(bus_level), .wake_level(wake_level),
        .inhibit_en(inhibit_en), .path_en(path_en), .term_en(term_en),
        .rxd_pull_low(rxd_pull_low), .txd_strong_pd(txd_strong_pd),
        .txd_weak_pd(txd_weak_pd)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver side: queue an expectation, then hold inputs while it is compared.
    task automatic expect_pins(input string tag, input logic [5:0] v);
        exp_q.push_back(v);
        tag_q.push_back(tag);
        wait_cyc(3);
    endtask

    // Monitor: compare each queued expectation against the outputs.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                logic [5:0] e;
                logic [5:0] a;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {inhibit_en, path_en, term_en, rxd_pull_low, txd_strong_pd, txd_weak_pd};
                checks++;
                if (a !== e) begin
                    fails++;
                    $display("FAIL %s actual=%b expected=%b", t, a, e);
                end
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        wait_cyc(4);
        expect_pins("R1 reset held", P_OFF);
        rst_n = 1'b1;
        wait_cyc(3);
        expect_pins("R1 after reset", P_OFF);

        supply_hi = 1'b1; wait_cyc(3); supply_hi = 1'b0;
        expect_pins("R2 power-up to pre-normal", P_PRE);

        enable_pin = 1'b1; wait_cyc(ENON * DIV + 20);
        expect_pins("R3 enable to normal", P_NORM);

        enable_pin = 1'b0; wait_cyc(ENOFF * DIV + 20);
        expect_pins("R4 disable to sleep", P_SLEEP);

        enable_pin = 1'b1; wait_cyc(15); enable_pin = 1'b0; wait_cyc(ENON * DIV + 20);
        expect_pins("R5 short enable ignored", P_SLEEP);

        bus_level = 1'b0; wait_cyc((BUSF - 2) * DIV); bus_level = 1'b1; wait_cyc(20);
        expect_pins("R6 short dominant ignored", P_SLEEP);

        bus_level = 1'b0; wait_cyc(BUSF * DIV + 20); bus_level = 1'b1; wait_cyc(3);
        expect_pins("R7 bus wake to pre-normal", P_PRE_B);

        enable_pin = 1'b1; wait_cyc(3);
        expect_pins("R9 enable clears bus flags", P_PRE);
        wait_cyc(ENON * DIV + 20);
        expect_pins("R3 pre-normal to normal after wake", P_NORM);

        enable_pin = 1'b0; wait_cyc(ENOFF * DIV + 20);
        expect_pins("R4 back to sleep", P_SLEEP);

        wake_level = 1'b0; wait_cyc(WAKEF * DIV + 20); wake_level = 1'b1; wait_cyc(3);
        expect_pins("R8 local wake to pre-normal", P_PRE_L);

        enable_pin = 1'b1; wait_cyc(3);
        expect_pins("R9 enable clears local flags", P_PRE);
        wait_cyc(ENON * DIV + 20);
        expect_pins("R3 normal again", P_NORM);

        bus_level = 1'b0; wait_cyc(5);
        enable_pin = 1'b0; wait_cyc(ENOFF * DIV + 20);
        expect_pins("R4 sleep with bus dominant", P_SLEEP);
        wait_cyc(BUSF * DIV * 2);
        expect_pins("R6 held dominant without edge ignored", P_SLEEP);
        bus_level = 1'b1; wait_cyc(10);
        expect_pins("R6 release without wake", P_SLEEP);

        bus_level = 1'b0; wake_level = 1'b0; wait_cyc(BUSF * DIV + 20);
        bus_level = 1'b1; wake_level = 1'b1; wait_cyc(3);
        expect_pins("R12 simultaneous wake prefers local", P_PRE_L);

        enable_pin = 1'b1; wait_cyc(ENON * DIV + 20);
        enable_pin = 1'b0; wait_cyc(ENOFF * DIV + 20);
        expect_pins("R4 sleep before enable wake", P_SLEEP);
        enable_pin = 1'b1; wait_cyc(ENON * DIV + 20);
        expect_pins("R10 enable wakes sleep to normal", P_NORM);

        supply_lo = 1'b1; wait_cyc(3);
        expect_pins("R11 undervoltage from normal", P_OFF);
        supply_lo = 1'b0; supply_hi = 1'b1; wait_cyc(3); supply_hi = 1'b0;
        wait_cyc(3);
        expect_pins("R2 re-power with enable high to normal", P_NORM);
        supply_lo = 1'b1; wait_cyc(3);
        expect_pins("R11 undervoltage again", P_OFF);
        supply_lo = 1'b0;

        wait_cyc(5);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule